// File: doc/BRIEF.md
# Self-Programming Command Sequencer

This block holds the command register that software uses to reprogram a microcontroller's own program memory. It also sequences those commands. Software writes one or more command bits together with an enable bit. That write opens a short acceptance window. A store strobe or a load strobe from the CPU that lands inside the window carries out the selected action:

- page write
- page erase
- temporary buffer fill
- signature-table read
- fuse/lock read

A buffer clear is carried out at once, without any strobe. If no strobe arrives, the window closes on its own and the register returns to zero.

Page write and page erase are long operations. For these the block raises a CPU-halt output for a parameterised number of cycles that stands for the flash programming time, and it clears the register when that time is over. A combinational read multiplexer replaces the normal program-memory byte with signature, fuse or lock data while a read command is armed. The flash array and the temporary buffer live outside this block; it only issues pulses and addresses to them. All pins are plain control and status signals, and none carries back-pressure.

Top module: `selfprog_seq`

## Requirements
- R1: The command register reads as {2'b00, sig_rd(bit5), buf_clr(bit4), fuse_rd(bit3), pg_write(bit2), pg_erase(bit1), enable(bit0)}. Bits 7:6 always read zero and the register resets to 8'h00.
- R2: A write with bit2 and bit0 set arms a page write. A store strobe at any of the four clock edges after the write edge produces a one-cycle fl_start with fl_erase=0 and fl_page=zptr[ZW-1:WORD_BITS+1], due one cycle after the strobe edge. data_in has no effect on this command.
- R3: A write with bit1 and bit0 set (and bit2 clear) behaves like R2 but drives fl_erase=1.
- R4: If no store strobe arrives by the fourth edge after arming, the register reads 8'h00 and a later strobe produces no fl_start and no buf_we.
- R5: After a page write or page erase launches, cpu_halt is high for exactly BUSY_CYCLES cycles starting one cycle after the strobe edge. When it drops, the register reads 8'h00.
- R6: A write of bit0 alone arms a buffer fill. A store strobe within four edges pulses buf_we one cycle later, with buf_waddr=zptr[WORD_BITS:1] and buf_wdata=data_in. The register then reads 8'h00.
- R7: With bit5 and bit0 written, ld_rdata equals sig_rdata while a load strobe is driven before or at the third edge after the write. From the fourth edge on it equals pm_rdata.
- R8: With bit3 and bit0 written, a load strobe within three edges sees fuse_rdata on ld_rdata when zptr[0]=0 and lock_rdata when zptr[0]=1.
- R9: A write with bit4 and bit0 set (bits 2 and 1 clear) pulses buf_clear for one cycle right after the write edge, and the register reads 8'h00.
- R10: While cpu_halt is high, register writes and strobes are ignored, and the register keeps reading bit0 plus the active write or erase bit.
- R11: When several command bits are written with bit0, only one is taken, in the priority page write > page erase > buffer clear > signature read > fuse read. At most one of fl_start, buf_we and buf_clear is high in any cycle.
- R12: A write with bit0 clear stores bits 5:0 for readback but arms nothing, so a following store strobe does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Command register write strobe |
| reg_wdata | input | 8 | Command register write data |
| reg_rdata | output | 8 | Command register read value |
| st_strobe | input | 1 | CPU store-to-program-memory strobe |
| ld_strobe | input | 1 | CPU load-from-program-memory strobe |
| zptr | input | ZW | Byte address pointer |
| data_in | input | 16 | Word to place in the temporary buffer |
| pm_rdata | input | 8 | Normal program-memory byte |
| sig_rdata | input | 8 | Signature-table byte |
| fuse_rdata | input | 8 | Fuse byte |
| lock_rdata | input | 8 | Lock byte |
| ld_rdata | output | 8 | Byte returned to the CPU on a load |
| fl_start | output | 1 | One-cycle launch of a page operation |
| fl_erase | output | 1 | Type of launched operation: 1 erase, 0 write |
| fl_page | output | ZW-WORD_BITS-1 | Page address of the launched operation |
| buf_we | output | 1 | Temporary buffer write pulse |
| buf_waddr | output | WORD_BITS | Word address in the buffer |
| buf_wdata | output | 16 | Word written into the buffer |
| buf_clear | output | 1 | Temporary buffer clear pulse |
| cpu_halt | output | 1 | Holds the CPU during a page operation |

## Verification
All inputs are driven on the falling edge. The bench therefore counts edges: a write is taken at edge 0, and a strobe placed after edge d-1 is taken at edge d.

- ld_rdata is combinational. It is sampled just after the strobe is driven, before edge d.
- fl_start, buf_we and buf_clear are registered. They are sampled at the falling edge that follows the capturing edge.
- The halt length is counted over falling edges, and the register is read only after that count plus margin.
- The window boundaries get a strobe exactly at the last accepted edge and one edge later: d=4/5 for stores and d=3/4 for loads.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  localparam int B_EN    = 0;
  localparam int B_ERASE = 1;
  localparam int B_WRITE = 2;
  localparam int B_FUSE  = 3;
  localparam int B_CLR   = 4;
  localparam int B_SIG   = 5;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_FILL, CMD_WRITE, CMD_ERASE, CMD_CLEAR, CMD_SIGRD, CMD_FUSERD
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] w);
    if (!w[B_EN])         return CMD_NONE;
    else if (w[B_WRITE])  return CMD_WRITE;
    else if (w[B_ERASE])  return CMD_ERASE;
    else if (w[B_CLR])    return CMD_CLEAR;
    else if (w[B_SIG])    return CMD_SIGRD;
    else if (w[B_FUSE])   return CMD_FUSERD;
    else                  return CMD_FILL;
  endfunction

  function automatic logic [5:0] cmd_bits(input cmd_e c);
    logic [5:0] b;
    b = '0;
    case (c)
      CMD_WRITE:  b[B_WRITE] = 1'b1;
      CMD_ERASE:  b[B_ERASE] = 1'b1;
      CMD_SIGRD:  b[B_SIG]   = 1'b1;
      CMD_FUSERD: b[B_FUSE]  = 1'b1;
      default:    b = '0;
    endcase
    if (c != CMD_NONE && c != CMD_CLEAR) b[B_EN] = 1'b1;
    return b;
  endfunction

  function automatic logic is_store_cmd(input cmd_e c);
    return (c == CMD_FILL) || (c == CMD_WRITE) || (c == CMD_ERASE);
  endfunction

  function automatic logic is_load_cmd(input cmd_e c);
    return (c == CMD_SIGRD) || (c == CMD_FUSERD);
  endfunction
endpackage

// File: rtl/selfprog_arm_win.sv
module selfprog_arm_win #(
  parameter int MAX_WIN = 4,
  localparam int CW = $clog2(MAX_WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          kill,
  input  logic          hit,
  output logic          armed,
  output logic          timeout
);
  logic [CW-1:0] cnt_q;

  assign armed   = (cnt_q != '0);
  assign timeout = (cnt_q == CW'(1)) && !load && !kill && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (load)                          cnt_q <= load_val;
    else if (kill || hit || cnt_q == CW'(1)) cnt_q <= '0;
    else if (armed)                         cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/selfprog_busy_tmr.sv
module selfprog_busy_tmr #(
  parameter int CYCLES = 32000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/selfprog_rd_mux.sv
module selfprog_rd_mux (
  input  logic       sig_sel,
  input  logic       fuse_sel,
  input  logic       z0,
  input  logic [7:0] pm_rdata,
  input  logic [7:0] sig_rdata,
  input  logic [7:0] fuse_rdata,
  input  logic [7:0] lock_rdata,
  output logic [7:0] ld_rdata
);
  always_comb begin
    if (sig_sel)       ld_rdata = sig_rdata;
    else if (fuse_sel) ld_rdata = z0 ? lock_rdata : fuse_rdata;
    else               ld_rdata = pm_rdata;
  end
endmodule

// File: rtl/selfprog_seq.sv
module selfprog_seq
  import selfprog_pkg::*;
#(
  parameter int ZW          = 16,
  parameter int WORD_BITS   = 5,
  parameter int ST_WIN      = 4,
  parameter int LD_WIN      = 3,
  parameter int BUSY_CYCLES = 32000,
  localparam int PAGE_W  = ZW - WORD_BITS - 1,
  localparam int MAX_WIN = (ST_WIN > LD_WIN) ? ST_WIN : LD_WIN,
  localparam int WCW     = $clog2(MAX_WIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 st_strobe,
  input  logic                 ld_strobe,
  input  logic [ZW-1:0]        zptr,
  input  logic [15:0]          data_in,
  input  logic [7:0]           pm_rdata,
  input  logic [7:0]           sig_rdata,
  input  logic [7:0]           fuse_rdata,
  input  logic [7:0]           lock_rdata,
  output logic [7:0]           ld_rdata,
  output logic                 fl_start,
  output logic                 fl_erase,
  output logic [PAGE_W-1:0]    fl_page,
  output logic                 buf_we,
  output logic [WORD_BITS-1:0] buf_waddr,
  output logic [15:0]          buf_wdata,
  output logic                 buf_clear,
  output logic                 cpu_halt
);
  logic [5:0] ctl_q;
  cmd_e       cmd_q;
  cmd_e       new_cmd;
  logic       armed, timeout, busy, done;
  logic       wr_ok, arm_now, st_hit, ld_hit, launch_pg;
  logic [WCW-1:0] win_val;

  assign new_cmd   = decode_cmd(reg_wdata);
  assign wr_ok     = reg_we && !busy;
  assign arm_now   = wr_ok && (is_store_cmd(new_cmd) || is_load_cmd(new_cmd));
  assign win_val   = is_load_cmd(new_cmd) ? WCW'(LD_WIN) : WCW'(ST_WIN);
  assign st_hit    = armed && !wr_ok && st_strobe && is_store_cmd(cmd_q);
  assign ld_hit    = armed && !wr_ok && ld_strobe && is_load_cmd(cmd_q);
  assign launch_pg = st_hit && (cmd_q == CMD_WRITE || cmd_q == CMD_ERASE);

  selfprog_arm_win #(.MAX_WIN(MAX_WIN)) u_win (
    .clk(clk), .rst_n(rst_n),
    .load(arm_now), .load_val(win_val), .kill(wr_ok),
    .hit(st_hit || ld_hit), .armed(armed), .timeout(timeout)
  );

  selfprog_busy_tmr #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(launch_pg), .busy(busy), .done(done)
  );

  selfprog_rd_mux u_mux (
    .sig_sel(armed && cmd_q == CMD_SIGRD),
    .fuse_sel(armed && cmd_q == CMD_FUSERD),
    .z0(zptr[0]),
    .pm_rdata(pm_rdata), .sig_rdata(sig_rdata),
    .fuse_rdata(fuse_rdata), .lock_rdata(lock_rdata),
    .ld_rdata(ld_rdata)
  );

  assign reg_rdata = {2'b00, ctl_q};
  assign cpu_halt  = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      cmd_q     <= CMD_NONE;
      fl_start  <= 1'b0;
      fl_erase  <= 1'b0;
      fl_page   <= '0;
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
      buf_clear <= 1'b0;
    end else begin
      fl_start  <= 1'b0;
      buf_we    <= 1'b0;
      buf_clear <= 1'b0;
      if (wr_ok) begin
        if (new_cmd == CMD_NONE) begin
          ctl_q <= reg_wdata[5:0];
          cmd_q <= CMD_NONE;
        end else if (new_cmd == CMD_CLEAR) begin
          ctl_q     <= '0;
          cmd_q     <= CMD_NONE;
          buf_clear <= 1'b1;
        end else begin
          ctl_q <= cmd_bits(new_cmd);
          cmd_q <= new_cmd;
        end
      end else if (st_hit) begin
        if (cmd_q == CMD_FILL) begin
          buf_we    <= 1'b1;
          buf_waddr <= zptr[WORD_BITS:1];
          buf_wdata <= data_in;
          ctl_q     <= '0;
          cmd_q     <= CMD_NONE;
        end else begin
          fl_start <= 1'b1;
          fl_erase <= (cmd_q == CMD_ERASE);
          fl_page  <= zptr[ZW-1:WORD_BITS+1];
        end
      end else if (ld_hit || timeout || done) begin
        ctl_q <= '0;
        cmd_q <= CMD_NONE;
      end
    end
  end
endmodule

// File: rtl/selfprog_chk.sv
module selfprog_chk #(
  parameter int BUSY_CYCLES = 32000,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_rdata,
  input logic       fl_start,
  input logic       buf_we,
  input logic       buf_clear,
  input logic       cpu_halt
);
  logic [CW-1:0] halt_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halt_len <= '0;
    else if (cpu_halt) halt_len <= halt_len + CW'(1);
    else               halt_len <= '0;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:6] == 2'b00);
  assert_start_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> cpu_halt);
  assert_halt_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (halt_len < CW'(BUSY_CYCLES)));
  assert_clear_after_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_halt) |-> reg_rdata == 8'h00);
  assert_fill_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> reg_rdata == 8'h00);
  assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> !buf_clear);
  assert_busy_shows_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (reg_rdata[0] && (reg_rdata[1] ^ reg_rdata[2])));
  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_start, buf_we, buf_clear}));
endmodule

bind selfprog_seq selfprog_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .fl_start(fl_start),
  .buf_we(buf_we), .buf_clear(buf_clear), .cpu_halt(cpu_halt)
);

// File: tb/sim_selfprog_seq.sv
module sim_selfprog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 20;
  localparam int WB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic st_strobe = 1'b0, ld_strobe = 1'b0;
  logic [15:0] zptr = '0;
  logic [15:0] data_in = 16'hBEEF;
  logic [7:0] pm_rdata = 8'h11, sig_rdata = 8'h5A, fuse_rdata = 8'hC3, lock_rdata = 8'h3C;
  logic [7:0] ld_rdata;
  logic fl_start, fl_erase, buf_we, buf_clear, cpu_halt;
  logic [9:0] fl_page;
  logic [4:0] buf_waddr;
  logic [15:0] buf_wdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfprog_seq #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .st_strobe(st_strobe), .ld_strobe(ld_strobe),
    .zptr(zptr), .data_in(data_in), .pm_rdata(pm_rdata), .sig_rdata(sig_rdata),
    .fuse_rdata(fuse_rdata), .lock_rdata(lock_rdata), .ld_rdata(ld_rdata),
    .fl_start(fl_start), .fl_erase(fl_erase), .fl_page(fl_page),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_clear(buf_clear), .cpu_halt(cpu_halt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: store 0 none,1 fill,2 write,3 erase; load 0 pm,1 sig,2 fuse,3 lock
  typedef struct packed {
    logic [7:0]  cmd;
    logic [2:0]  dly;
    logic        ld;
    logic [15:0] z;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{8'h05, 3'd1, 1'b0, 16'h1234, 2'd2},  // R2 first edge
    '{8'h05, 3'd4, 1'b0, 16'hF0C2, 2'd2},  // R2 last edge
    '{8'h05, 3'd5, 1'b0, 16'h1234, 2'd0},  // R4 expired
    '{8'h03, 3'd2, 1'b0, 16'hABCE, 2'd3},  // R3
    '{8'h03, 3'd5, 1'b0, 16'hABCE, 2'd0},  // R4 erase expired
    '{8'h01, 3'd3, 1'b0, 16'h003E, 2'd1},  // R6
    '{8'h01, 3'd5, 1'b0, 16'h0012, 2'd0},  // R4 fill expired
    '{8'h21, 3'd3, 1'b1, 16'h0002, 2'd1},  // R7 last edge
    '{8'h21, 3'd4, 1'b1, 16'h0002, 2'd0},  // R7 expired
    '{8'h09, 3'd1, 1'b1, 16'h0000, 2'd2},  // R8 fuse
    '{8'h09, 3'd2, 1'b1, 16'h0001, 2'd3},  // R8 lock
    '{8'h0F, 3'd1, 1'b0, 16'h4444, 2'd2},  // R11 write wins
    '{8'h23, 3'd1, 1'b0, 16'h8080, 2'd3},  // R11 erase wins over sig
    '{8'h29, 3'd1, 1'b1, 16'h0001, 2'd1},  // R11 sig wins over fuse
    '{8'h04, 3'd1, 1'b0, 16'h1234, 2'd0}   // R12 no enable
  };

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int halt_cnt;
    repeat (3) @(negedge clk);
    check(reg_rdata == 8'h00 && !cpu_halt && !fl_start && !buf_we && !buf_clear,
          "R1 reset", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = v.cmd; zptr = v.z;
      @(negedge clk);
      reg_we = 1'b0;
      repeat (int'(v.dly) - 1) @(negedge clk);
      if (v.ld) begin
        logic [7:0] e;
        ld_strobe = 1'b1;
        e = (v.kind == 2'd1) ? sig_rdata : (v.kind == 2'd2) ? fuse_rdata :
            (v.kind == 2'd3) ? lock_rdata : pm_rdata;
        #1 check(ld_rdata == e, "R7/R8/R11 load data", ld_rdata, e);
        @(negedge clk); ld_strobe = 1'b0;
      end else begin
        st_strobe = 1'b1;
        @(negedge clk); st_strobe = 1'b0;
        check(fl_start == (v.kind >= 2) && buf_we == (v.kind == 1),
              "R2/R3/R4/R6/R12 store action", {fl_start, buf_we}, v.kind);
        if (v.kind >= 2) begin
          check(fl_erase == (v.kind == 3), "R2/R3 op type", fl_erase, v.kind == 3);
          check(fl_page == v.z[15:WB+1], "R2 page addr", fl_page, v.z[15:WB+1]);
          check(cpu_halt, "R5 halt raised", cpu_halt, 1);
        end
        if (v.kind == 1) begin
          check(buf_waddr == v.z[WB:1] && buf_wdata == 16'hBEEF, "R6 fill data",
                {buf_waddr, buf_wdata}, {v.z[WB:1], 16'hBEEF});
        end
      end
      repeat (BUSY + 2) @(negedge clk);
      if (v.cmd == 8'h04)
        check(reg_rdata == 8'h04, "R12 readback kept", reg_rdata, 8'h04);
      else
        check(reg_rdata == 8'h00 && !cpu_halt, "R4/R5 register cleared", reg_rdata, 0);
      write_reg(8'h00);
    end

    // R1: reserved bits read zero
    write_reg(8'hFE);
    check(reg_rdata == 8'h3E, "R1 reserved zero", reg_rdata, 8'h3E);
    write_reg(8'h00);
    // R1: armed readback
    write_reg(8'h05);
    check(reg_rdata == 8'h05, "R1 armed readback", reg_rdata, 8'h05);
    repeat (6) @(negedge clk);
    // R9: buffer clear
    @(negedge clk); reg_we = 1'b1; reg_wdata = 8'h11;
    @(negedge clk); reg_we = 1'b0;
    check(buf_clear == 1'b1 && reg_rdata == 8'h00, "R9 clear pulse", buf_clear, 1);
    @(negedge clk);
    check(buf_clear == 1'b0, "R9 clear one cycle", buf_clear, 0);
    // R11: write beats clear
    write_reg(8'h15);
    check(buf_clear == 1'b0 && reg_rdata == 8'h05, "R11 write over clear", reg_rdata, 8'h05);
    repeat (6) @(negedge clk);

    // R5 + R10: exact halt length, ignored writes/strobes while busy
    zptr = 16'h0040;
    write_reg(8'h05);
    st_strobe = 1'b1;
    @(negedge clk); st_strobe = 1'b0;
    halt_cnt = 0;
    while (cpu_halt && halt_cnt < BUSY + 10) begin
      if (halt_cnt == 3) begin reg_we = 1'b1; reg_wdata = 8'h01; st_strobe = 1'b1; end
      if (halt_cnt == 4) begin
        reg_we = 1'b0; st_strobe = 1'b0;
        check(reg_rdata == 8'h05 && !buf_we, "R10 busy ignores write", reg_rdata, 8'h05);
      end
      if (halt_cnt == 5) check(!buf_we && !fl_start, "R10 busy ignores strobe", buf_we, 0);
      halt_cnt++;
      @(negedge clk);
    end
    check(halt_cnt == BUSY, "R5 halt length", halt_cnt, BUSY);
    check(reg_rdata == 8'h00, "R5 cleared at end", reg_rdata, 0);

    // R4: strobe after expiry is a no-op
    write_reg(8'h01);
    repeat (6) @(negedge clk);
    st_strobe = 1'b1;
    @(negedge clk); st_strobe = 1'b0;
    check(!buf_we && !fl_start, "R4 late strobe", buf_we, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule